// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Edge/Level Sensing

This block keeps the pending-request bits of an interrupt controller with a parameterised number of lines. Each request line has its own sensing-mode bit. With that bit at 1 the line is level-sensed, and its request bit tracks the input. With the bit at 0 the line is edge-sensed: a rising input latches a request, and the request stays set until the line is acknowledged.

The raw request lines are asynchronous, so each one passes through a multi-flop synchroniser before any edge detection. A byte-wide write port loads the sensing-mode register. A build-time mask limits which of its bits can be written, so a line reserved for a fixed purpose can be pinned to edge mode. An acknowledge port carries a line number. It clears that line's request only when the line is edge-sensed. The priority logic that sits downstream reads the request register and the mode register directly.

Top module: `irq_request_latch`

## Requirements
- R1: A synchronous active-high reset clears the request register, the sensing-mode register, the synchroniser stages and the per-line previous-level history.
- R2: A mode write stores `mode_wr_data & WR_MASK`; with the default `WR_MASK = 8'hFB`, bit 2 always reads 0. Without a write, the mode register holds its value.
- R3: A line whose mode bit is 1 (level) has a request bit equal to its synchronised input. The bit is set while the input is high and cleared when the input is low.
- R4: A line whose mode bit is 0 (edge) sets its request only when the synchronised input is 1 and the line's previous-level history is 0. Holding the input high does not set the request again. Dropping the input does not clear the request.
- R5: With `ack_valid` high, the line numbered by `ack_line` (bit index 0..7) has its request cleared if that line is in edge mode. Other lines are not touched. With `ack_valid` low, nothing is cleared.
- R6: An acknowledge of a level-mode line has no effect on its request bit.
- R7: If a new edge is seen on a line in the same cycle that the line is acknowledged, the request stays set.
- R8: A change on `irq_lines` reaches `req_o` on the third rising clock edge after it is applied (two synchroniser flops plus the request register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Asynchronous request inputs |
| mode_wr_en | input | 1 | Write strobe for the sensing-mode register |
| mode_wr_data | input | NUM_LINES | Write data; 1 = level, 0 = edge |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | IDX_W | Number of the line being acknowledged |
| req_o | output | NUM_LINES | Request register |
| mode_o | output | NUM_LINES | Sensing-mode register |

## Verification
The bench targets these failure modes:
- Acknowledging a level line. A design that clears it anyway drops a request whose input is still high.
- An acknowledge that lands in the same cycle as a fresh edge. A design that favours the clear loses that interrupt for good.
- A line held high after its acknowledge. A design missing the previous-level history re-raises the request on every cycle.
- The masked mode bit and the exact three-edge latency, checked cycle by cycle. A wrong mask lets the reserved line become level-sensed, and a missing or extra synchroniser stage shifts every request by one cycle.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] WR_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)        mode_q <= '0;
    else if (wr_en) mode_q <= wr_data & WR_MASK;
  end
endmodule

// File: rtl/irq_req_cell.sv
module irq_req_cell
  import irq_latch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  sense_e sense,
  input  logic   level_in,
  input  logic   ack_hit,
  output logic   req_q
);
  logic seen_high;
  logic rise;

  assign rise = level_in & ~seen_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      seen_high <= 1'b0;
    end else begin
      seen_high <= level_in;
      if (sense == SENSE_LEVEL) req_q <= level_in;
      else                      req_q <= (req_q & ~ack_hit) | rise;
    end
  end
endmodule

// File: rtl/irq_request_latch.sv
module irq_request_latch
  import irq_latch_pkg::*;
#(
  parameter int                   NUM_LINES   = 8,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] WR_MASK     = 8'hFB,
  localparam int                  IDX_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 mode_wr_en,
  input  logic [NUM_LINES-1:0] mode_wr_data,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_line,
  output logic [NUM_LINES-1:0] req_o,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] lvl_sync;
  logic [NUM_LINES-1:0] ack_dec;

  irq_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(irq_lines), .sync_out(lvl_sync)
  );

  irq_mode_reg #(.WIDTH(NUM_LINES), .WR_MASK(WR_MASK)) u_mode (
    .clk(clk), .rst(rst), .wr_en(mode_wr_en), .wr_data(mode_wr_data),
    .mode_q(mode_o)
  );

  assign ack_dec = ack_valid ? (NUM_LINES'(1) << ack_line) : '0;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_req_cell u_cell (
      .clk(clk), .rst(rst),
      .sense(sense_e'(mode_o[g])),
      .level_in(lvl_sync[g]),
      .ack_hit(ack_dec[g]),
      .req_q(req_o[g])
    );
  end
endmodule

// File: rtl/irq_request_latch_chk.sv
module irq_request_latch_chk #(
  parameter int                   NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = 8'hFB,
  localparam int                  IDX_W     = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 mode_wr_en,
  input logic [NUM_LINES-1:0] mode_wr_data,
  input logic                 ack_valid,
  input logic [IDX_W-1:0]     ack_line,
  input logic [NUM_LINES-1:0] req_o,
  input logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] ack_vec;
  assign ack_vec = ack_valid ? (NUM_LINES'(1) << ack_line) : '0;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (req_o == '0 && mode_o == '0)); // R1

  AST_MODE_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
    mode_wr_en |=> mode_o == ($past(mode_wr_data) & WR_MASK)); // R2

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !mode_wr_en |=> $stable(mode_o)); // R2

  AST_EDGE_DROP_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (~req_o & $past(req_o) & ~$past(mode_o) & ~$past(ack_vec)) == '0); // R5
endmodule

bind irq_request_latch irq_request_latch_chk #(
  .NUM_LINES(NUM_LINES), .WR_MASK(WR_MASK)
) u_chk (.*);

// File: tb/irq_request_latch_test.sv
module irq_request_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MASK = 8'hFB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_lines = '0;
  logic       mode_wr_en = 1'b0;
  logic [7:0] mode_wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] req_o, mode_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  string tag  = "R1";

  logic [7:0] m_s1, m_s2, m_prev, m_req, m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_request_latch uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .req_o(req_o), .mode_o(mode_o)
  );

  task automatic model_edge();
    logic [7:0] nreq;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_req = '0; m_mode = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (m_mode[i]) nreq[i] = m_s2[i];
        else nreq[i] = (m_req[i] & ~(ack_valid && ack_line == 3'(i)))
                       | (m_s2[i] & ~m_prev[i]);
      end
      m_req = nreq; m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_lines;
      if (mode_wr_en) m_mode = mode_wr_data & MASK;
    end
  endtask

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] in, input logic we, input logic [7:0] wd,
                      input logic av, input logic [2:0] al);
    irq_lines = in; mode_wr_en = we; mode_wr_data = wd;
    ack_valid = av; ack_line = al;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " req"}, req_o, m_req);
    check({tag, " mode"}, mode_o, m_mode);
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    step(8'hFF, 1'b1, 8'hFF, 1'b1, 3'd1);
    step(8'hFF, 1'b0, 8'h00, 1'b0, 3'd0);
    rst = 1'b0;
    tag = "R1";
    check("R1 reset req", req_o, 8'h00);
    check("R1 reset mode", mode_o, 8'h00);

    tag = "R2";
    step(8'h00, 1'b1, 8'hFF, 1'b0, 3'd0);
    check("R2 masked write", mode_o, 8'hFB);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
    check("R2 hold", mode_o, 8'hFB);
    step(8'h00, 1'b1, 8'h01, 1'b0, 3'd0);
    repeat (3) step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0);

    tag = "R8";
    step(8'h03, 1'b0, 8'h00, 1'b0, 3'd0);
    check("R8 after 1 edge", req_o, 8'h00);
    step(8'h03, 1'b0, 8'h00, 1'b0, 3'd0);
    check("R8 after 2 edges", req_o, 8'h00);
    step(8'h03, 1'b0, 8'h00, 1'b0, 3'd0);
    check("R8 after 3 edges", req_o, 8'h03);

    tag = "R4";
    repeat (5) step(8'h03, 1'b0, 8'h00, 1'b0, 3'd0);
    check("R4 held high", req_o, 8'h03);

    tag = "R6";
    step(8'h03, 1'b0, 8'h00, 1'b1, 3'd0);
    check("R6 level ack ignored", req_o, 8'h03);

    tag = "R5";
    step(8'h03, 1'b0, 8'h00, 1'b1, 3'd1);
    check("R5 edge ack clears", req_o, 8'h01);
    repeat (4) step(8'h03, 1'b0, 8'h00, 1'b0, 3'd0);
    check("R5 no re-set while held", req_o, 8'h01);

    tag = "R3";
    repeat (3) step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
    check("R3 level drops", req_o, 8'h00);

    tag = "R7";
    step(8'h08, 1'b0, 8'h00, 1'b0, 3'd0);
    step(8'h08, 1'b0, 8'h00, 1'b0, 3'd0);
    step(8'h08, 1'b0, 8'h00, 1'b1, 3'd3);
    check("R7 edge beats ack", req_o, 8'h08);
    step(8'h00, 1'b0, 8'h00, 1'b1, 3'd3);
    check("R7 later ack clears", req_o, 8'h00);

    tag = "R4 sweep";
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] in;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in = irq_lines ^ (lfsr[7:0] & {lfsr[15:12], lfsr[11:8]});
      step(in, (lfsr[11:8] == 4'h5), lfsr[15:8], lfsr[2], lfsr[14:12]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule